// File: doc/BRIEF.md
# PS/2 Device-Side Host-to-Device Byte Receiver

This block sits on the device end of a PS/2 link and accepts one byte sent by the host. On this link the device generates every clock pulse. The block starts when the host asks to send. The host holds the clock line low for at least 100 µs, pulls data low and then lets the clock go high. The low data level at that point is the start bit. The block then produces the clock pulses and shifts in the frame. When the stop bit is high, it pulls data low for one more pulse to acknowledge the frame. It then hands the byte to a command handler, together with flags for a parity error and a framing error.

The line interface uses open-drain enables. A high enable means "pull this line low". The line level inputs are assumed to be synchronized already. When the stop bit is low, the block does not give up. It keeps pulsing the clock until the host releases data, then acknowledges, and reports a framing error so that the handler can ask for a Resend. If the host pulls the clock low while the block has it released, the block drops the byte and goes back to idle. The half period of the generated clock is the parameter `HALF_TICKS`, the same setting the transmitter uses.

Top module: `ps2_dev_rx`

## Requirements
- R1: During reset and in the first cycle after it, `clk_oe_o`, `dat_oe_o` and `rx_valid_o` are 0, so both lines are released.
- R2: While idle, the block starts clocking only if the clock line is high and the data line is low at detection and are still in that state `HALF_TICKS` cycles later. A low pulse on data that ends sooner produces no clock pulse.
- R3: Each generated clock pulse drives `clk_oe_o` high for exactly `HALF_TICKS` cycles and then releases it for `HALF_TICKS` cycles.
- R4: Data is sampled at the end of each low phase. Pulse 1 takes the start bit, pulses 2 to 9 take data bits 0 to 7 (least significant bit first) and pulse 10 takes the parity bit. The byte is presented on `rx_byte_o`, with bit 0 being the first data bit received.
- R5: At the end of the released phase after pulse 10, a high data line (stop bit 1) makes the block drive `dat_oe_o` high for exactly one extra clock low phase (`HALF_TICKS` cycles). A normal frame therefore has 11 pulses in total.
- R6: Parity is odd. When the eight data bits and the parity bit together hold an even number of ones, `rx_parity_err_o` is 1 alongside `rx_valid_o`; otherwise it is 0.
- R7: If the stop bit is low, the block goes on pulsing until data is seen high at the end of a released phase. It then gives the acknowledge pulse and reports `rx_frame_err_o` = 1 with `rx_valid_o`. A stop bit held low for n extra pulses gives 11+n pulses in total.
- R8: If the clock line is low at the end of any released phase, the frame is dropped: no `rx_valid_o`, both enables go to 0 and no further pulses are produced until a new request-to-send.
- R9: `rx_valid_o` is a single-cycle strobe that comes one cycle after the final released phase. `rx_byte_o`, `rx_parity_err_o` and `rx_frame_err_o` change only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_line_i | input | 1 | Synchronized level of the PS/2 clock line |
| dat_line_i | input | 1 | Synchronized level of the PS/2 data line |
| clk_oe_o | output | 1 | 1 = pull the clock line low |
| dat_oe_o | output | 1 | 1 = pull the data line low |
| rx_byte_o | output | DATA_BITS (8) | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe: frame complete |
| rx_parity_err_o | output | 1 | Parity error in the last frame |
| rx_frame_err_o | output | 1 | Stop bit was low in the last frame; a Resend is needed |

## Verification
A bench host model sends frames clocked by the block's own generated pulses. The frames carry random bytes and directed bytes: all zeros, all ones and a single high bit. These show whether the bits are ordered least significant bit first and whether odd parity is computed over all nine bits. Random frames also corrupt the parity bit, which separates the parity flag from the byte path. Other frames hold the stop bit low for one to three extra pulses. Counting the pulses and the acknowledge cycles in those frames tells the normal acknowledge apart from the stretched framing-error path. Separate directed runs pull the clock low in the middle of a frame and pulse the data line briefly while idle; both must produce no strobe and no extra pulse.

// File: rtl/ps2rx_pkg.sv
// Package: shared state types for the PS/2 device-side receiver.
// Assumes: used only by the ps2rx_* modules and ps2_dev_rx.
package ps2rx_pkg;

    // Line-handling state of the receiver
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // lines released, watching for request-to-send
        ST_RTS  = 2'd1,   // request-to-send seen, confirming after one half period
        ST_LOW  = 2'd2,   // clock driven low, data sampled at end
        ST_HIGH = 2'd3    // clock released, host line checks at end
    } rx_state_e;

    // Which part of the frame the current pulse belongs to
    typedef enum logic [1:0] {
        PH_BITS    = 2'd0, // start, data and parity pulses
        PH_STRETCH = 2'd1, // stop bit was low, pulsing until data high
        PH_ACK     = 2'd2, // acknowledge pulse, data pulled low
        PH_TAIL    = 2'd3  // released phase after acknowledge
    } rx_phase_e;

endpackage

// File: rtl/ps2rx_half_timer.sv
// Module: half-period timer of the generated PS/2 clock.
// Loads HALF_TICKS-1 on 'load' and counts down; 'expire' is high in the
// last cycle of a half period. Assumes HALF_TICKS >= 1.
module ps2rx_half_timer #(
    parameter int HALF_TICKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expire
);
    localparam int CW = $clog2(HALF_TICKS + 1);
    localparam logic [CW-1:0] RELOAD = CW'(HALF_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Count down one half period, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= RELOAD;
        else if (load)
            cnt_q <= RELOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Last cycle of the half period
    always_comb expire = (cnt_q == '0);

endmodule

// File: rtl/ps2rx_shift.sv
// Module: frame shift register for data and parity bits.
// Shifts bits in at the top, so the first bit received ends up in bit 0.
// After DATA_BITS+1 shifts, data is in the low bits and parity is in the top bit.
module ps2rx_shift #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic                 bit_in,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 parity_ok_o
);
    localparam int SR_W = DATA_BITS + 1;

    logic [SR_W-1:0] sr_q;

    // Capture one sampled line bit per shift request
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            sr_q <= '0;
        else if (shift_en)
            sr_q <= {bit_in, sr_q[SR_W-1:1]};
    end

    // Data bits and odd-parity check over data plus parity
    always_comb begin
        data_o      = sr_q[DATA_BITS-1:0];
        parity_ok_o = ^sr_q;
    end

endmodule

// File: rtl/ps2_dev_rx.sv
// Module: PS/2 device-side receiver for host-to-device bytes.
// Detects request-to-send, generates the clock, samples start, data and
// parity at the end of each low phase, and acknowledges by pulling data low for
// one extra pulse. A low stop bit stretches the frame until data is released.
// Assumes clk_line_i and dat_line_i are already synchronized, and that the
// enables drive open-drain pads (1 = pull the line low).
module ps2_dev_rx
    import ps2rx_pkg::*;
#(
    parameter int HALF_TICKS = 5000,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_line_i,
    input  logic                 dat_line_i,
    output logic                 clk_oe_o,
    output logic                 dat_oe_o,
    output logic [DATA_BITS-1:0] rx_byte_o,
    output logic                 rx_valid_o,
    output logic                 rx_parity_err_o,
    output logic                 rx_frame_err_o
);
    localparam int LAST_IDX = DATA_BITS + 1;          // pulse index of parity
    localparam int IW       = $clog2(LAST_IDX + 1);
    localparam logic [IW-1:0] LAST = IW'(LAST_IDX);

    rx_state_e st_q;
    rx_phase_e ph_q;
    logic [IW-1:0] idx_q;
    logic ferr_q;
    logic expire, tmr_load, shift_en, sr_clear, finish;
    logic [DATA_BITS-1:0] sr_data;
    logic sr_par_ok;

    ps2rx_half_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .expire (expire)
    );

    ps2rx_shift #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (sr_clear),
        .shift_en    (shift_en),
        .bit_in      (dat_line_i),
        .data_o      (sr_data),
        .parity_ok_o (sr_par_ok)
    );

    // Control decode: timer reload, sampling and frame completion
    always_comb begin
        tmr_load = (st_q == ST_IDLE) || expire;
        sr_clear = (st_q == ST_IDLE);
        shift_en = (st_q == ST_LOW) && expire && (ph_q == PH_BITS) && (idx_q != '0);
        finish   = (st_q == ST_HIGH) && expire && clk_line_i && (ph_q == PH_TAIL);
        clk_oe_o = (st_q == ST_LOW);
        dat_oe_o = (st_q == ST_LOW) && (ph_q == PH_ACK);
    end

    // Frame sequencer: request-to-send, pulse phases, stop check, abort
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ph_q   <= PH_BITS;
            idx_q  <= '0;
            ferr_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (clk_line_i && !dat_line_i)
                        st_q <= ST_RTS;
                end
                ST_RTS: begin
                    if (expire) begin
                        if (clk_line_i && !dat_line_i) begin
                            st_q   <= ST_LOW;
                            ph_q   <= PH_BITS;
                            idx_q  <= '0;
                            ferr_q <= 1'b0;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                end
                ST_LOW: begin
                    if (expire) begin
                        st_q <= ST_HIGH;
                        if (ph_q == PH_ACK)
                            ph_q <= PH_TAIL;
                    end
                end
                ST_HIGH: begin
                    if (expire) begin
                        if (!clk_line_i) begin
                            st_q <= ST_IDLE;             // host inhibits: drop frame
                        end else begin
                            st_q <= ST_LOW;
                            unique case (ph_q)
                                PH_BITS: begin
                                    if (idx_q == LAST) begin
                                        if (dat_line_i) begin
                                            ph_q <= PH_ACK;
                                        end else begin
                                            ph_q   <= PH_STRETCH;
                                            ferr_q <= 1'b1;
                                        end
                                    end else begin
                                        idx_q <= idx_q + 1'b1;
                                    end
                                end
                                PH_STRETCH: begin
                                    if (dat_line_i)
                                        ph_q <= PH_ACK;
                                end
                                PH_ACK: ph_q <= PH_TAIL;
                                PH_TAIL: st_q <= ST_IDLE;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // Result registers: strobe plus byte and flags, updated together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_o      <= 1'b0;
            rx_byte_o       <= '0;
            rx_parity_err_o <= 1'b0;
            rx_frame_err_o  <= 1'b0;
        end else begin
            rx_valid_o <= finish;
            if (finish) begin
                rx_byte_o       <= sr_data;
                rx_parity_err_o <= !sr_par_ok;
                rx_frame_err_o  <= ferr_q;
            end
        end
    end

endmodule

// File: rtl/ps2rx_checker.sv
// Module: assertion checker for ps2_dev_rx, attached by bind.
// Observes ports only, plus a run-length counter of the generated clock.
module ps2rx_checker #(
    parameter int HALF_TICKS = 5000,
    parameter int DATA_BITS  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clk_line_i,
    input logic                 dat_line_i,
    input logic                 clk_oe_o,
    input logic                 dat_oe_o,
    input logic [DATA_BITS-1:0] rx_byte_o,
    input logic                 rx_valid_o,
    input logic                 rx_parity_err_o,
    input logic                 rx_frame_err_o
);
    int run_len;

    // Length of the current run of clock-low drive
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= 0;
        else if (clk_oe_o)
            run_len <= run_len + 1;
        else
            run_len <= 0;
    end

    assert_reset_release_R1: assert property (@(posedge clk)
        !rst_n |=> (!clk_oe_o && !dat_oe_o && !rx_valid_o));

    assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_oe_o) |-> (run_len == HALF_TICKS));

    assert_ack_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dat_oe_o |-> clk_oe_o);

    assert_parity_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_parity_err_o) |-> rx_valid_o);

    assert_frame_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_frame_err_o) |-> rx_valid_o);

    assert_done_line_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(clk_line_i));

    assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_strobe_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> (!clk_oe_o && !dat_oe_o));

    assert_byte_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte_o) |-> rx_valid_o);

endmodule

bind ps2_dev_rx ps2rx_checker #(.HALF_TICKS(HALF_TICKS), .DATA_BITS(DATA_BITS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .clk_line_i      (clk_line_i),
    .dat_line_i      (dat_line_i),
    .clk_oe_o        (clk_oe_o),
    .dat_oe_o        (dat_oe_o),
    .rx_byte_o       (rx_byte_o),
    .rx_valid_o      (rx_valid_o),
    .rx_parity_err_o (rx_parity_err_o),
    .rx_frame_err_o  (rx_frame_err_o)
);

// File: tb/tb_ps2_dev_rx.sv
// Bench: host model on a wired-AND PS/2 link driving ps2_dev_rx.
module tb_ps2_dev_rx;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_clk_low = 1'b0;
    logic host_dat = 1'b1;
    logic clk_line, dat_line;
    logic clk_oe, dat_oe, rx_valid, rx_perr, rx_ferr;
    logic [7:0] rx_byte;

    int n_checks = 0;
    int n_fails = 0;
    int valid_cnt = 0, pulse_cnt = 0, ack_cyc = 0, low_cyc = 0;
    logic [7:0] last_byte = '0;
    logic last_perr = 1'b0, last_ferr = 1'b0;
    logic prev_oe = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    assign clk_line = ~clk_oe & ~host_clk_low;
    assign dat_line = ~dat_oe & host_dat;

    ps2_dev_rx #(.HALF_TICKS(HALF), .DATA_BITS(8)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .clk_line_i      (clk_line),
        .dat_line_i      (dat_line),
        .clk_oe_o        (clk_oe),
        .dat_oe_o        (dat_oe),
        .rx_byte_o       (rx_byte),
        .rx_valid_o      (rx_valid),
        .rx_parity_err_o (rx_perr),
        .rx_frame_err_o  (rx_ferr)
    );

    // Monitor: accumulate strobes, pulses and drive cycles away from the edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                valid_cnt <= valid_cnt + 1;
                last_byte <= rx_byte;
                last_perr <= rx_perr;
                last_ferr <= rx_ferr;
            end
            if (clk_oe && !prev_oe) pulse_cnt <= pulse_cnt + 1;
            if (clk_oe) low_cyc <= low_cyc + 1;
            if (dat_oe) ack_cyc <= ack_cyc + 1;
        end
        prev_oe <= clk_oe;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic odd_par(input logic [7:0] b);
        return ~^b;
    endfunction

    // Host sends one frame; stop held low for 'extra' extra pulses
    task automatic run_frame(input logic [7:0] b, input bit bad, input int extra);
        logic [8:0] bits;
        int v0, p0, a0, l0;
        bit got;
        bits = {odd_par(b) ^ bad, b};
        v0 = valid_cnt; p0 = pulse_cnt; a0 = ack_cyc; l0 = low_cyc;
        host_clk_low = 1'b1;
        repeat (20) @(posedge clk);
        host_dat = 1'b0;
        repeat (4) @(posedge clk);
        host_clk_low = 1'b0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk_oe);
            host_dat = bits[i];
        end
        @(negedge clk_oe);
        host_dat = (extra == 0);
        for (int k = 0; k < extra; k++) @(negedge clk_oe);
        host_dat = 1'b1;
        got = 1'b0;
        for (int c = 0; c < 8 * HALF && !got; c++) begin
            @(negedge clk);
            if (valid_cnt != v0) got = 1'b1;
        end
        @(negedge clk);
        check(valid_cnt == v0 + 1, "R9", "strobe count", valid_cnt - v0, 1);
        check(last_byte == b, "R4", "byte", last_byte, b);
        check(last_perr == bad, "R6", "parity flag", last_perr, bad);
        check(last_ferr == (extra != 0), "R7", "frame flag", last_ferr, extra != 0);
        check(pulse_cnt - p0 == 11 + extra, (extra != 0) ? "R7" : "R5", "pulses",
              pulse_cnt - p0, 11 + extra);
        check(ack_cyc - a0 == HALF, "R5", "ack cycles", ack_cyc - a0, HALF);
        check(low_cyc - l0 == (11 + extra) * HALF, "R3", "low cycles",
              low_cyc - l0, (11 + extra) * HALF);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int p0, v0;
        void'($urandom(32'h1d5e_ed01));
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(!clk_oe && !dat_oe && !rx_valid, "R1", "in reset", {clk_oe, dat_oe, rx_valid}, 0);
        @(posedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!clk_oe && !dat_oe && !rx_valid, "R1", "after reset", {clk_oe, dat_oe, rx_valid}, 0);

        // Directed frames
        run_frame(8'h00, 1'b0, 0);
        run_frame(8'hFF, 1'b0, 0);
        run_frame(8'h80, 1'b0, 0);
        run_frame(8'h01, 1'b1, 0);
        run_frame(8'hA5, 1'b0, 1);
        run_frame(8'h3C, 1'b1, 3);

        // Short data pulse while idle: no clocking (R2)
        repeat (10) @(posedge clk);
        p0 = pulse_cnt;
        host_dat = 1'b0;
        repeat (2) @(posedge clk);
        host_dat = 1'b1;
        repeat (6 * HALF) @(negedge clk);
        check(pulse_cnt == p0, "R2", "pulses after glitch", pulse_cnt - p0, 0);

        // Host inhibits mid-frame: byte dropped (R8)
        v0 = valid_cnt;
        host_clk_low = 1'b1;
        repeat (20) @(posedge clk);
        host_dat = 1'b0;
        repeat (4) @(posedge clk);
        host_clk_low = 1'b0;
        repeat (4) @(negedge clk_oe);
        host_clk_low = 1'b1;
        repeat (4 * HALF) @(negedge clk);
        p0 = pulse_cnt;
        check(!clk_oe && !dat_oe, "R8", "enables after abort", {clk_oe, dat_oe}, 0);
        host_dat = 1'b1;
        repeat (2) @(posedge clk);
        host_clk_low = 1'b0;
        repeat (6 * HALF) @(negedge clk);
        check(pulse_cnt == p0, "R8", "pulses after abort", pulse_cnt - p0, 0);
        check(valid_cnt == v0, "R8", "strobe after abort", valid_cnt - v0, 0);

        // Constrained random frames
        for (int n = 0; n < 40; n++) begin
            logic [7:0] b;
            bit bad;
            int extra;
            b = 8'($urandom);
            bad = ($urandom % 4) == 0;
            extra = (($urandom % 5) == 0) ? int'($urandom % 3) + 1 : 0;
            run_frame(b, bad, extra);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule